// File: doc/BRIEF.md
# Operand Specifier Decoder and Address Generator

This block takes one operand specifier from an instruction byte stream and resolves it. A specifier is one to six bytes long. The result is one of four things: a register number, a short literal, an immediate long value, or an effective memory address. The decoder also reports how many bytes the specifier used. When the mode steps a register, it sends one register write-back request. When the mode is indirect, it fetches the pointer through a memory read port. The caller supplies the stream as a six-byte little-endian window whose byte 0 is the first specifier byte. It also supplies the operand size code and the address of that first byte (`pc_in`). The program counter is never read from the register file. Every form that uses it takes the counter as `pc_in` plus the consumed length, or takes a value straight from the stream.

A transaction starts with a one-cycle `start` while the block is idle. The block then reads the base register and the index register one after the other through a single combinational register-file port. If the mode is indirect, it holds a memory request until it is acknowledged. It finishes with a one-cycle `done` pulse. While `done` is high, the kind, value, length and write-back outputs are valid.

Top module: `opspec_decoder`

## Requirements
- R1: A first byte from 0x00 to 0x3F gives kind LIT (code 1). The value is the byte's six low bits, the length is 1, and there is no write-back and no memory read.
- R2: A byte 0x5n with n below 15 gives kind REG (code 0). The value is n, the length is 1, and there is no write-back.
- R3: Byte 0x6n gives address Rn. Byte 0x8n (n below 15) gives address Rn and a write-back of Rn plus the operand size. Byte 0x7n gives address Rn minus the size, with that same value written back to n. All three give kind MEM (code 3) and length 1. Size code 0/1/2/3 means 1/2/4/8 bytes.
- R4: Byte 0x9n (n below 15) reads memory at Rn. The data read is the address, and Rn plus 4 is written back.
- R5: High nibbles A, C and E take a 1, 2 or 4 byte little-endian displacement from the bytes that follow. The displacement is sign-extended and added to Rn. The length is 2, 3 or 5.
- R6: High nibbles B, D and F form the same sum as R5, read memory there, and use the data read as the address.
- R7: Byte 0x8F gives kind IMM (code 2), with the next four bytes as a little-endian value. Byte 0x9F gives kind MEM with those four bytes as the address and no memory read. Both have length 5 and never write back.
- R8: Displacement forms with register 15 use `pc_in` plus the total specifier length as the base.
- R9: A first byte 0x4x makes the next byte the base specifier. The final address is the base result plus Rx shifted left by the size code. The length grows by one, and write-back follows the base mode.
- R10: Kind FAULT (code 4) with length 0, no write-back and no memory read is reported in these cases:
  - an index prefix whose base byte has a high nibble of 5 or below, or is 0x8F;
  - an index prefix whose index register is 15;
  - high nibble 5, 6 or 7 with register 15.
- R11: Every `start` accepted while idle produces exactly one single-cycle `done`. A memory request stays asserted, with a stable address, until it is acknowledged.
- R12: After reset, `done`, `mem_req` and `wb_valid` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin decoding the current window (taken while idle) |
| spec_win | input | 48 | Six specifier bytes, byte 0 in bits 7:0 |
| op_size | input | 2 | Operand size code: 1, 2, 4 or 8 bytes |
| pc_in | input | 32 | Address of specifier byte 0 |
| rf_addr | output | 4 | Register-file read index |
| rf_data | input | 32 | Register-file read data, same cycle |
| mem_req | output | 1 | Pointer read request |
| mem_addr | output | 32 | Pointer read address |
| mem_ack | input | 1 | Read data valid, ends the request |
| mem_data | input | 32 | Read data |
| done | output | 1 | One-cycle result strobe |
| kind | output | 3 | Result kind code |
| value | output | 32 | Literal, immediate, register number or address |
| length | output | 4 | Specifier bytes consumed |
| wb_valid | output | 1 | Register write-back request, with done |
| wb_reg | output | 4 | Write-back register |
| wb_data | output | 32 | Write-back value |

## Verification
The assertions assume three things about the environment:
- `start` is pulsed only while the block is idle;
- `rf_data` answers the index that `rf_addr` shows in the same cycle;
- `mem_ack` appears only while `mem_req` is high.

The bench keeps to all three. It issues one transaction at a time and waits for `done` plus one idle cycle before the next. It models the register file as a pure function of `rf_addr`. It raises the acknowledge from a small counter two cycles into each request, which exercises the hold-while-waiting property. The stimulus sweeps every first byte at every size code with two displacement tails of opposite sign. It also sweeps every index register against every base byte.

// File: rtl/opspec_pkg.sv
package opspec_pkg;

    localparam int XLEN       = 32;
    localparam int REG_W      = 4;
    localparam int WIN_BYTES  = 6;
    localparam int WIN_W      = WIN_BYTES * 8;
    localparam int LEN_W      = 4;
    localparam int SZ_W       = 2;
    localparam logic [REG_W-1:0] PC_REG = '1;

    typedef enum logic [2:0] {
        K_REG   = 3'd0,
        K_LIT   = 3'd1,
        K_IMM   = 3'd2,
        K_MEM   = 3'd3,
        K_FAULT = 3'd4
    } kind_e;

    typedef enum logic [1:0] {
        WB_NONE   = 2'd0,
        WB_INC_SZ = 2'd1,
        WB_INC_4  = 2'd2,
        WB_DEC_SZ = 2'd3
    } wb_e;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_RBASE = 3'd1,
        ST_RIDX  = 3'd2,
        ST_MREQ  = 3'd3,
        ST_FIN   = 3'd4
    } st_e;

    typedef struct packed {
        kind_e             kind;
        logic              has_idx;
        logic [REG_W-1:0]  xr;
        logic [3:0]        mode;
        logic [REG_W-1:0]  rn;
        logic [XLEN-1:0]   val;
        logic [LEN_W-1:0]  len;
        logic              need_base;
        logic              pc_base;
        logic              deferred;
        wb_e               wb;
    } spec_t;

    // bytes of trailing data carried by a base specifier
    function automatic logic [2:0] tail_bytes(input logic [3:0] m, input logic [REG_W-1:0] r);
        case (m)
            4'hA, 4'hB: tail_bytes = 3'd1;
            4'hC, 4'hD: tail_bytes = 3'd2;
            4'hE, 4'hF: tail_bytes = 3'd4;
            4'h8, 4'h9: tail_bytes = (r == PC_REG) ? 3'd4 : 3'd0;
            default:    tail_bytes = 3'd0;
        endcase
    endfunction

    function automatic logic [XLEN-1:0] widen(input logic [31:0] raw, input logic [2:0] n);
        case (n)
            3'd1:    widen = {{24{raw[7]}}, raw[7:0]};
            3'd2:    widen = {{16{raw[15]}}, raw[15:0]};
            default: widen = raw;
        endcase
    endfunction

endpackage

// File: rtl/opspec_parse.sv
module opspec_parse
    import opspec_pkg::*;
(
    input  logic [WIN_W-1:0] win,
    output spec_t            spec
);
    logic [7:0]       lead;
    logic [7:0]       bsel;
    logic             idx;
    logic [3:0]       m;
    logic [REG_W-1:0] r;
    logic [2:0]       nt;
    logic [31:0]      raw;
    logic             bad;

    always_comb begin
        lead = win[7:0];
        idx  = (lead[7:4] == 4'h4);
        bsel = idx ? win[15:8] : lead;
        m    = bsel[7:4];
        r    = bsel[3:0];
        raw  = idx ? win[16 +: 32] : win[8 +: 32];
        nt   = tail_bytes(m, r);

        bad = 1'b0;
        if (idx && ((m <= 4'h5) || (bsel == 8'h8F) || (lead[3:0] == PC_REG)))
            bad = 1'b1;
        if (((m == 4'h5) || (m == 4'h6) || (m == 4'h7)) && (r == PC_REG))
            bad = 1'b1;

        spec = '0;
        spec.has_idx = idx;
        spec.xr      = lead[3:0];
        spec.mode    = m;
        spec.rn      = r;

        if (bad) begin
            spec.kind = K_FAULT;
        end else if (m < 4'h4) begin
            spec.kind = K_LIT;
            spec.val  = {{(XLEN-6){1'b0}}, bsel[5:0]};
        end else if (m == 4'h5) begin
            spec.kind = K_REG;
            spec.val  = {{(XLEN-REG_W){1'b0}}, r};
        end else if ((m == 4'h8) && (r == PC_REG)) begin
            spec.kind = K_IMM;
            spec.val  = raw;
        end else begin
            spec.kind = K_MEM;
            spec.val  = widen(raw, nt);
        end

        if (!bad)
            spec.len = LEN_W'(idx) + LEN_W'(1) + LEN_W'(nt);

        if (spec.kind == K_MEM) begin
            spec.need_base = (r != PC_REG);
            spec.pc_base   = (r == PC_REG) && (m >= 4'hA);
            spec.deferred  = ((m == 4'h9) && (r != PC_REG)) ||
                             (m == 4'hB) || (m == 4'hD) || (m == 4'hF);
            if (r != PC_REG) begin
                case (m)
                    4'h7:    spec.wb = WB_DEC_SZ;
                    4'h8:    spec.wb = WB_INC_SZ;
                    4'h9:    spec.wb = WB_INC_4;
                    default: spec.wb = WB_NONE;
                endcase
            end
        end
    end
endmodule

// File: rtl/opspec_agen.sv
module opspec_agen
    import opspec_pkg::*;
(
    input  kind_e             kind,
    input  logic [3:0]        mode,
    input  logic [REG_W-1:0]  rn,
    input  logic [XLEN-1:0]   sval,
    input  logic [LEN_W-1:0]  len,
    input  logic              has_idx,
    input  logic              pc_base,
    input  logic              deferred,
    input  wb_e               wb,
    input  logic [SZ_W-1:0]   sz,
    input  logic [XLEN-1:0]   pc,
    input  logic [XLEN-1:0]   breg,
    input  logic [XLEN-1:0]   xval,
    input  logic [XLEN-1:0]   mptr,
    output logic [XLEN-1:0]   pre_addr,
    output logic [XLEN-1:0]   result,
    output logic [XLEN-1:0]   wb_val
);
    logic [XLEN-1:0] step;
    logic [XLEN-1:0] base;
    logic [XLEN-1:0] eff;

    always_comb begin
        step = XLEN'(1) << sz;
        base = pc_base ? (pc + XLEN'(len)) : breg;

        case (mode)
            4'h6:       pre_addr = base;
            4'h7:       pre_addr = breg - step;
            4'h8, 4'h9: pre_addr = (rn == PC_REG) ? sval : breg;
            default:    pre_addr = base + sval;
        endcase

        eff = (deferred ? mptr : pre_addr) + (has_idx ? (xval << sz) : '0);

        case (kind)
            K_MEM:   result = eff;
            K_FAULT: result = '0;
            default: result = sval;
        endcase

        case (wb)
            WB_INC_SZ: wb_val = breg + step;
            WB_INC_4:  wb_val = breg + XLEN'(4);
            WB_DEC_SZ: wb_val = breg - step;
            default:   wb_val = '0;
        endcase
    end
endmodule

// File: rtl/opspec_decoder.sv
module opspec_decoder
    import opspec_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start,
    input  logic [WIN_W-1:0]     spec_win,
    input  logic [SZ_W-1:0]      op_size,
    input  logic [XLEN-1:0]      pc_in,
    output logic [REG_W-1:0]     rf_addr,
    input  logic [XLEN-1:0]      rf_data,
    output logic                 mem_req,
    output logic [XLEN-1:0]      mem_addr,
    input  logic                 mem_ack,
    input  logic [XLEN-1:0]      mem_data,
    output logic                 done,
    output logic [2:0]           kind,
    output logic [XLEN-1:0]      value,
    output logic [LEN_W-1:0]     length,
    output logic                 wb_valid,
    output logic [REG_W-1:0]     wb_reg,
    output logic [XLEN-1:0]      wb_data
);
    spec_t            parsed;
    spec_t            sp;
    st_e              st;
    logic [XLEN-1:0]  pc_q;
    logic [SZ_W-1:0]  sz_q;
    logic [XLEN-1:0]  breg_q;
    logic [XLEN-1:0]  xreg_q;
    logic [XLEN-1:0]  mptr_q;
    logic [XLEN-1:0]  pre_addr;
    logic [XLEN-1:0]  result;
    logic [XLEN-1:0]  wb_val;

    opspec_parse u_parse (
        .win  (spec_win),
        .spec (parsed)
    );

    opspec_agen u_agen (
        .kind     (sp.kind),
        .mode     (sp.mode),
        .rn       (sp.rn),
        .sval     (sp.val),
        .len      (sp.len),
        .has_idx  (sp.has_idx),
        .pc_base  (sp.pc_base),
        .deferred (sp.deferred),
        .wb       (sp.wb),
        .sz       (sz_q),
        .pc       (pc_q),
        .breg     (breg_q),
        .xval     (xreg_q),
        .mptr     (mptr_q),
        .pre_addr (pre_addr),
        .result   (result),
        .wb_val   (wb_val)
    );

    function automatic st_e after_regs(input spec_t s, input logic base_done, input logic idx_done);
        if (s.kind != K_MEM)                   after_regs = ST_FIN;
        else if (s.need_base && !base_done)    after_regs = ST_RBASE;
        else if (s.has_idx && !idx_done)       after_regs = ST_RIDX;
        else if (s.deferred)                   after_regs = ST_MREQ;
        else                                   after_regs = ST_FIN;
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= ST_IDLE;
            sp     <= '0;
            pc_q   <= '0;
            sz_q   <= '0;
            breg_q <= '0;
            xreg_q <= '0;
            mptr_q <= '0;
        end else begin
            case (st)
                ST_IDLE: if (start) begin
                    sp   <= parsed;
                    pc_q <= pc_in;
                    sz_q <= op_size;
                    st   <= after_regs(parsed, 1'b0, 1'b0);
                end
                ST_RBASE: begin
                    breg_q <= rf_data;
                    st     <= after_regs(sp, 1'b1, 1'b0);
                end
                ST_RIDX: begin
                    xreg_q <= rf_data;
                    st     <= after_regs(sp, 1'b1, 1'b1);
                end
                ST_MREQ: if (mem_ack) begin
                    mptr_q <= mem_data;
                    st     <= ST_FIN;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    assign rf_addr  = (st == ST_RIDX) ? sp.xr : sp.rn;
    assign mem_req  = (st == ST_MREQ);
    assign mem_addr = pre_addr;
    assign done     = (st == ST_FIN);
    assign kind     = sp.kind;
    assign value    = result;
    assign length   = sp.len;
    assign wb_valid = done && (sp.wb != WB_NONE);
    assign wb_reg   = sp.rn;
    assign wb_data  = wb_val;

    // R11
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R11
    mem_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

    // R7
    wb_not_pc_chk: assert property (@(posedge clk) disable iff (rst)
        wb_valid |-> (wb_reg != PC_REG));

    // R10
    fault_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (done && (kind == 3'd4)) |-> (!wb_valid && (length == '0)));

    // R1
    lit_len_chk: assert property (@(posedge clk) disable iff (rst)
        (done && (kind == 3'd1)) |-> (length == LEN_W'(1) && !wb_valid));

    // R3
    wb_with_done_chk: assert property (@(posedge clk) disable iff (rst)
        wb_valid |-> done);

    // R12
    reset_quiet_chk: assert property (@(posedge clk)
        $past(rst) |-> (!done && !mem_req && !wb_valid));
endmodule

// File: tb/opspec_decoder_bench.sv
`timescale 1ns/1ps
module opspec_decoder_bench;
    logic        clk = 1'b0;
    logic        rst;
    logic        start;
    logic [47:0] spec_win;
    logic [1:0]  op_size;
    logic [31:0] pc_in;
    logic [3:0]  rf_addr;
    logic [31:0] rf_data;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic        mem_ack;
    logic [31:0] mem_data;
    logic        done;
    logic [2:0]  kind;
    logic [31:0] value;
    logic [3:0]  length;
    logic        wb_valid;
    logic [3:0]  wb_reg;
    logic [31:0] wb_data;

    int checks = 0;
    int failures = 0;
    logic [1:0] ack_cnt;
    logic       mem_seen;

    always #4 clk = ~clk;

    function automatic logic [31:0] regv(input logic [3:0] n);
        regv = 32'h0001_0000 + {28'b0, n} * 32'h0000_0F13;
    endfunction

    function automatic logic [31:0] memv(input logic [31:0] a);
        memv = {a[15:0], a[31:16]} ^ 32'h5A5A_C3C3;
    endfunction

    assign rf_data  = regv(rf_addr);
    assign mem_data = memv(mem_addr);
    assign mem_ack  = mem_req && (ack_cnt == 2'd2);

    always @(posedge clk) begin
        if (rst) ack_cnt <= 2'd0;
        else if (mem_req && !mem_ack) ack_cnt <= ack_cnt + 2'd1;
        else ack_cnt <= 2'd0;
        if (rst || start) mem_seen <= 1'b0;
        else if (mem_req) mem_seen <= 1'b1;
    end

    opspec_decoder u_opspec_decoder (
        .clk(clk), .rst(rst), .start(start), .spec_win(spec_win),
        .op_size(op_size), .pc_in(pc_in), .rf_addr(rf_addr), .rf_data(rf_data),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_data(mem_data),
        .done(done), .kind(kind), .value(value), .length(length),
        .wb_valid(wb_valid), .wb_reg(wb_reg), .wb_data(wb_data)
    );

    task automatic check(input bit ok, input string tag, input logic [76:0] act, input logic [76:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Reference: expected fields computed from the requirement text
    task automatic expect_of(input logic [47:0] w, input logic [1:0] sz, input logic [31:0] pc,
                             output logic [76:0] packed_exp, output string tag);
        logic [7:0]  b0, bb;
        logic [3:0]  m, r, x;
        int          o, n;
        logic [31:0] lng, d, bv, addr, s;
        logic [2:0]  k;
        logic [31:0] val;
        logic [3:0]  len;
        logic        wv, mr;
        logic [3:0]  wr;
        logic [31:0] wd;
        bit          idx, flt;
        b0  = w[7:0];
        idx = (b0[7:4] == 4'h4);
        o   = idx ? 1 : 0;
        bb  = w[8*o +: 8];
        m   = bb[7:4];
        r   = bb[3:0];
        x   = b0[3:0];
        lng = w[8*(o+1) +: 32];
        s   = 32'd1 << sz;
        k = 3'd3; val = 0; len = 0; wv = 0; wr = 0; wd = 0; mr = 0; addr = 0;
        flt = (idx && (m < 4'h6 || bb == 8'h8F || x == 4'hF)) ||
              ((m == 4'h5 || m == 4'h6 || m == 4'h7) && r == 4'hF);
        tag = "R3";
        if (flt) begin
            k = 3'd4; tag = "R10";
        end else if (m < 4'h4) begin
            k = 3'd1; val = {26'b0, bb[5:0]}; len = 1; tag = "R1";
        end else if (m == 4'h5) begin
            k = 3'd0; val = {28'b0, r}; len = 1; tag = "R2";
        end else if (m == 4'h6) begin
            addr = regv(r); len = 4'(o + 1);
        end else if (m == 4'h7) begin
            addr = regv(r) - s; wv = 1; wr = r; wd = addr; len = 4'(o + 1);
        end else if (m == 4'h8 && r == 4'hF) begin
            k = 3'd2; val = lng; len = 4'(o + 5); tag = "R7";
        end else if (m == 4'h8) begin
            addr = regv(r); wv = 1; wr = r; wd = regv(r) + s; len = 4'(o + 1);
        end else if (m == 4'h9 && r == 4'hF) begin
            addr = lng; len = 4'(o + 5); tag = "R7";
        end else if (m == 4'h9) begin
            addr = memv(regv(r)); mr = 1; wv = 1; wr = r; wd = regv(r) + 4;
            len = 4'(o + 1); tag = "R4";
        end else begin
            n = (m < 4'hC) ? 1 : (m < 4'hE) ? 2 : 4;
            d = (n == 1) ? {{24{lng[7]}}, lng[7:0]} :
                (n == 2) ? {{16{lng[15]}}, lng[15:0]} : lng;
            len  = 4'(o + 1 + n);
            bv   = (r == 4'hF) ? pc + {28'b0, len} : regv(r);
            addr = bv + d;
            if (m[0]) begin addr = memv(addr); mr = 1; end
            tag = (r == 4'hF) ? "R8" : (m[0] ? "R6" : "R5");
        end
        if (!flt && idx) begin
            addr = addr + (regv(x) << sz);
            tag = "R9";
        end
        if (k == 3'd3) val = addr;
        packed_exp = {k, val, len, wv, wr, wd, mr};
    endtask

    task automatic run_one(input logic [47:0] w, input logic [1:0] sz, input logic [31:0] pc);
        logic [76:0] e, a;
        string tag;
        int waited;
        expect_of(w, sz, pc, e, tag);
        @(negedge clk);
        spec_win = w; op_size = sz; pc_in = pc; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        spec_win = 48'h0; pc_in = 32'h0;
        waited = 0;
        while (!done && waited < 40) begin
            @(negedge clk);
            waited++;
        end
        if (!done) begin
            check(1'b0, "R11 watchdog", 77'd0, 77'd1);
            return;
        end
        a = {kind, value, length, wb_valid,
             wb_valid ? wb_reg : 4'h0, wb_valid ? wb_data : 32'h0, mem_seen};
        check(a === e, tag, a, e);
        @(negedge clk);
        check(!done, "R11 single pulse", {76'd0, done}, 77'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        rst = 1'b1; start = 1'b0; spec_win = '0; op_size = '0; pc_in = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R12: quiet outputs during and right after reset
        check(!done && !mem_req && !wb_valid, "R12 reset",
              {74'd0, done, mem_req, wb_valid}, 77'd0);
        rst = 1'b0;
        @(negedge clk);
        check(!done && !mem_req && !wb_valid, "R12 idle",
              {74'd0, done, mem_req, wb_valid}, 77'd0);

        // R1..R8, R10: every first byte, every size, two tails of opposite sign
        for (int t = 0; t < 2; t++) begin
            for (int b = 0; b < 256; b++) begin
                for (int z = 0; z < 4; z++) begin
                    logic [47:0] w;
                    w = (t == 0) ? {8'h00, 8'h13, 8'h57, 8'h24, 8'h7E, 8'(b)}
                                 : {8'h00, 8'hC8, 8'h13, 8'hFE, 8'h85, 8'(b)};
                    run_one(w, 2'(z), 32'h0000_2000 + 32'(b) * 32'd4);
                end
            end
        end

        // R9, R10: every index register against every base byte
        for (int x = 0; x < 16; x++) begin
            for (int b = 0; b < 256; b++) begin
                logic [47:0] w;
                logic [1:0]  z;
                z = 2'(b) ^ 2'(x);
                w = {8'hC8, 8'h13, 8'hFE, 8'h85, 8'(b), 8'h40 | 8'(x)};
                run_one(w, z, 32'h0040_0000 + 32'(x) * 32'h100 + 32'(b));
            end
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule